// File: doc/BRIEF.md
# Direct-Mapped Write-Through Word Cache

This block sits between a 16-bit CPU bus and a slower main-memory port. It keeps 512 lines of one data word each, in a single RAM of 512 words by 36 bits. Each RAM word holds the data, the address tag and a valid flag. When the CPU reads, the block issues the memory request and the cache RAM read in the same cycle. It compares the tag one cycle later. On a hit it returns the cached word and raises an abort that cancels the pending memory read.

Every CPU write goes through to main memory. A write whose cacheable input is high also fills the indexed line with the new word. A cacheable read miss fills the line with the word that memory returns. Accesses marked non-cacheable never hit and never change the RAM. After reset the block writes zero to all 512 entries, one per clock, before it accepts any request. The CPU holds its request until it sees a one-cycle `cpu_ready` pulse. Main memory holds `mem_ack` high for one cycle when it completes, and never acknowledges in the cycle in which the request first appears.

Top module: `wt_word_cache`

## Requirements
- R1: After reset is released, the block spends exactly 512 clocks clearing entries 0 to 511. During that time `cpu_ready` and `mem_req` stay low and no request is accepted. A request held from the release is launched to memory in the 512th cycle after the release. Lines cached before a reset miss after it.
- R2: The byte address is split as follows: index = address bits 9:1 and tag = address bits 19:10. A RAM entry holds the data in bits 15:0, the tag in bits 25:16 and the valid flag in bit 35. Two addresses with the same index and different tags evict each other. Addresses that differ only in index bits coexist.
- R3: A cacheable read that hits raises `cpu_ready` in the clock after the request is accepted. In that cycle `cpu_rdata` is the cached word and `mem_abort` is high.
- R4: On a read miss, `cpu_ready` rises in the cycle in which `mem_ack` is high, and `cpu_rdata` equals `mem_rdata`. If the read is cacheable, a later read of the same word hits and returns that value.
- R5: Every write drives `mem_req` with `mem_we` high and the CPU's address and data, whether it hits or misses. The write completes only on `mem_ack`, so the word is present in main memory afterwards.
- R6: A cacheable write stores the data, tag and valid flag in the indexed entry. A following cacheable read of that word hits and returns the written data.
- R7: A non-cacheable access never hits, never raises `mem_abort` and never writes the RAM. A non-cacheable write leaves a cached copy at that address unchanged, and a non-cacheable read miss does not fill a line.
- R8: The memory request is raised combinationally in the cycle a request is accepted, in the same cycle as the cache RAM read.
- R9: Address bit 0 is ignored: byte addresses 2n and 2n+1 use the same line.
- R10: `cpu_ready` is a single-cycle pulse per request and is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | CPU request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_cacheable | input | 1 | Address lies in a cacheable region |
| cpu_addr | input | 20 | Byte address; bit 0 ignored |
| cpu_wdata | input | 16 | Write data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 16 | Read data, valid with `cpu_ready` |
| mem_req | output | 1 | Main-memory request |
| mem_we | output | 1 | Main-memory write enable |
| mem_addr | output | 20 | Main-memory byte address |
| mem_wdata | output | 16 | Main-memory write data |
| mem_abort | output | 1 | Cancels the pending memory read on a hit |
| mem_ack | input | 1 | One-cycle completion from main memory |
| mem_rdata | input | 16 | Main-memory read data, valid with `mem_ack` |

## Verification
The assertions check the following rules on every cycle:
- The bus stays quiet while the sweep runs.
- The sweep index advances by one per clock.
- An abort only appears together with a completing read hit.
- Each tag compare follows a cycle in which the memory request and the RAM read were both issued.
- A write never completes without a memory acknowledge.
- The RAM is never written for a non-cacheable access.
- The ready pulse lasts one cycle.

Only the bench scenarios can show the other behaviours:
- Data values are returned correctly on hits and fills.
- Lines with aliasing tags evict each other.
- A non-cacheable write leaves a stale cached copy untouched.
- The sweep lasts exactly 512 cycles.
- Entries are invalidated after a second reset.

// File: rtl/wtc_pkg.sv
`timescale 1ns/1ps
package wtc_pkg;

    parameter int ADDR_W  = 20;
    parameter int DATA_W  = 16;
    parameter int INDEX_W = 9;
    parameter int ENTRY_W = 36;
    parameter int TAG_W   = ADDR_W - 1 - INDEX_W;
    parameter int DEPTH   = 1 << INDEX_W;
    parameter int PAD_W   = ENTRY_W - 1 - TAG_W - DATA_W;

    // RAM word layout: valid at the top, tag directly above the data
    typedef struct packed {
        logic               valid;
        logic [PAD_W-1:0]   pad;
        logic [TAG_W-1:0]   tag;
        logic [DATA_W-1:0]  data;
    } entry_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOOK,
        ST_RD_WAIT,
        ST_WR_WAIT
    } state_t;

    typedef struct packed {
        logic               we;
        logic               cacheable;
        logic [INDEX_W-1:0] idx;
        logic [TAG_W-1:0]   tag;
        logic [ADDR_W-1:0]  addr;
        logic [DATA_W-1:0]  wdata;
    } req_t;

    function automatic logic [INDEX_W-1:0] index_of(input logic [ADDR_W-1:0] a);
        return a[INDEX_W:1];
    endfunction

    function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:INDEX_W+1];
    endfunction

    function automatic entry_t make_entry(input logic [TAG_W-1:0] t,
                                          input logic [DATA_W-1:0] d);
        entry_t e;
        e.valid = 1'b1;
        e.pad   = '0;
        e.tag   = t;
        e.data  = d;
        return e;
    endfunction

endpackage

// File: rtl/wtc_entry_ram.sv
`timescale 1ns/1ps
module wtc_entry_ram #(
    parameter int DEPTH = 512,
    parameter int WIDTH = 36,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic [AW-1:0]    addr,
    input  logic             we,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] store [DEPTH];

    // single port, one-clock registered read (old data on a write)
    always_ff @(posedge clk) begin
        if (we) begin
            store[addr] <= wdata;
        end
        rdata <= store[addr];
    end
endmodule

// File: rtl/wtc_init_sweep.sv
`timescale 1ns/1ps
module wtc_init_sweep #(
    parameter int DEPTH = 512,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    output logic          active,
    output logic [AW-1:0] idx
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b1;
            idx    <= '0;
        end else if (active) begin
            idx <= idx + 1'b1;
            if (idx == LAST) begin
                active <= 1'b0;
            end
        end
    end

    // R1: one entry per clock, in ascending order
    assert_sweep_step_R1: assert property (@(posedge clk) disable iff (rst)
        (active && idx != LAST) |=> (active && idx == $past(idx) + 1'b1));

    // R1: the sweep never restarts without a reset
    assert_sweep_once_R1: assert property (@(posedge clk) disable iff (rst)
        !active |=> !active);
endmodule

// File: rtl/wtc_ctrl.sv
`timescale 1ns/1ps
module wtc_ctrl
    import wtc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               sweep_active,
    input  logic [INDEX_W-1:0] sweep_idx,
    input  logic               cpu_req,
    input  logic               cpu_we,
    input  logic               cpu_cacheable,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic [DATA_W-1:0]  cpu_wdata,
    output logic               cpu_ready,
    output logic [DATA_W-1:0]  cpu_rdata,
    output logic               mem_req,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    output logic               mem_abort,
    input  logic               mem_ack,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic [INDEX_W-1:0] ram_addr,
    output logic               ram_we,
    output entry_t             ram_wdata,
    input  entry_t             ram_rdata
);
    state_t state, state_nxt;
    req_t   held, req_now, cur;
    logic   accept, tag_hit, hit, rd_done, wr_done, fill;
    logic   unused_ctrl;

    assign unused_ctrl = ^ram_rdata.pad;

    always_comb begin
        req_now.we        = cpu_we;
        req_now.cacheable = cpu_cacheable;
        req_now.idx       = index_of(cpu_addr);
        req_now.tag       = tag_of(cpu_addr);
        req_now.addr      = cpu_addr;
        req_now.wdata     = cpu_wdata;
    end

    assign accept  = (state == ST_IDLE) && cpu_req && !sweep_active;
    assign cur     = (state == ST_IDLE) ? req_now : held;

    // tag compare runs on the registered RAM output
    assign tag_hit = ram_rdata.valid && (ram_rdata.tag == held.tag) && held.cacheable;
    assign hit     = (state == ST_LOOK) && tag_hit;
    assign rd_done = mem_ack && (((state == ST_LOOK) && !tag_hit) || (state == ST_RD_WAIT));
    assign wr_done = mem_ack && (state == ST_WR_WAIT);
    assign fill    = rd_done && held.cacheable;

    // memory side: launched combinationally on accept, held until resolved
    assign mem_req   = accept || (state != ST_IDLE);
    assign mem_we    = mem_req && cur.we;
    assign mem_addr  = cur.addr;
    assign mem_wdata = cur.wdata;
    assign mem_abort = hit;

    assign cpu_ready = hit || rd_done || wr_done;
    always_comb begin
        if (hit) begin
            cpu_rdata = ram_rdata.data;
        end else if (rd_done) begin
            cpu_rdata = mem_rdata;
        end else begin
            cpu_rdata = '0;
        end
    end

    // RAM port: sweep first, then fill, then lookup or write-allocate
    always_comb begin
        if (sweep_active) begin
            ram_addr  = sweep_idx;
            ram_we    = 1'b1;
            ram_wdata = '0;
        end else if (fill) begin
            ram_addr  = held.idx;
            ram_we    = 1'b1;
            ram_wdata = make_entry(held.tag, mem_rdata);
        end else begin
            ram_addr  = cur.idx;
            ram_we    = accept && cpu_we && cpu_cacheable;
            ram_wdata = make_entry(cur.tag, cur.wdata);
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:    if (accept) state_nxt = cpu_we ? ST_WR_WAIT : ST_LOOK;
            ST_LOOK:    state_nxt = (hit || rd_done) ? ST_IDLE : ST_RD_WAIT;
            ST_RD_WAIT: if (mem_ack) state_nxt = ST_IDLE;
            ST_WR_WAIT: if (mem_ack) state_nxt = ST_IDLE;
            default:    state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            held  <= '0;
        end else begin
            state <= state_nxt;
            if (accept) begin
                held <= req_now;
            end
        end
    end

    // R1: bus stays quiet while entries are being cleared
    assert_quiet_sweep_R1: assert property (@(posedge clk) disable iff (rst)
        sweep_active |-> (!cpu_ready && !mem_req));

    // R3: an abort only accompanies a completing read hit
    assert_abort_hit_R3: assert property (@(posedge clk) disable iff (rst)
        mem_abort |-> (cpu_ready && mem_req && !mem_we));

    // R8: the compare follows a cycle that issued both memory and RAM reads
    assert_parallel_launch_R8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOOK) |-> ($past(mem_req) && $past(ram_addr) == held.idx));

    // R5: a write is never completed without main memory acknowledging
    assert_write_through_R5: assert property (@(posedge clk) disable iff (rst)
        (cpu_ready && held.we) |-> (mem_ack && mem_we));

    // R7: non-cacheable traffic leaves the RAM alone
    assert_nc_untouched_R7: assert property (@(posedge clk) disable iff (rst)
        (ram_we && !sweep_active) |-> cur.cacheable);

    // R10: ready is a single-cycle pulse
    assert_ready_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |=> !cpu_ready);
endmodule

// File: rtl/wt_word_cache.sv
`timescale 1ns/1ps
module wt_word_cache
    import wtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic              cpu_cacheable,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_abort,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    logic               sweep_active;
    logic [INDEX_W-1:0] sweep_idx;
    logic [INDEX_W-1:0] ram_addr;
    logic               ram_we;
    entry_t             ram_wdata;
    entry_t             ram_rdata;
    logic [ENTRY_W-1:0] ram_rdata_raw;

    assign ram_rdata = entry_t'(ram_rdata_raw);

    wtc_init_sweep #(.DEPTH(DEPTH)) u_sweep (
        .clk    (clk),
        .rst    (rst),
        .active (sweep_active),
        .idx    (sweep_idx)
    );

    wtc_entry_ram #(.DEPTH(DEPTH), .WIDTH(ENTRY_W)) u_ram (
        .clk   (clk),
        .addr  (ram_addr),
        .we    (ram_we),
        .wdata (ram_wdata),
        .rdata (ram_rdata_raw)
    );

    wtc_ctrl u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .sweep_active  (sweep_active),
        .sweep_idx     (sweep_idx),
        .cpu_req       (cpu_req),
        .cpu_we        (cpu_we),
        .cpu_cacheable (cpu_cacheable),
        .cpu_addr      (cpu_addr),
        .cpu_wdata     (cpu_wdata),
        .cpu_ready     (cpu_ready),
        .cpu_rdata     (cpu_rdata),
        .mem_req       (mem_req),
        .mem_we        (mem_we),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata),
        .mem_abort     (mem_abort),
        .mem_ack       (mem_ack),
        .mem_rdata     (mem_rdata),
        .ram_addr      (ram_addr),
        .ram_we        (ram_we),
        .ram_wdata     (ram_wdata),
        .ram_rdata     (ram_rdata)
    );
endmodule

// File: tb/wt_word_cache_test.sv
`timescale 1ns/1ps
module wt_word_cache_test;
    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0, cpu_we = 1'b0, cpu_cacheable = 1'b0;
    logic [19:0] cpu_addr = '0;
    logic [15:0] cpu_wdata = '0;
    logic        cpu_ready, mem_req, mem_we, mem_abort;
    logic [15:0] cpu_rdata, mem_wdata;
    logic [19:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = '0;

    int tests = 0, fails = 0, cyc = 0;

    always #2.5 clk = ~clk;

    wt_word_cache uut (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_cacheable(cpu_cacheable), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_abort(mem_abort), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    task automatic chk(input logic ok, input string rq, input string what,
                       input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // ---------------- main memory model ----------------
    logic [15:0] mm [int unsigned];
    int unsigned mcnt = 0;

    function automatic logic [15:0] mem_word(input int unsigned w);
        logic [15:0] lo;
        lo = w[15:0];
        return mm.exists(w) ? mm[w] : ((lo * 16'd37) ^ 16'hC3A5);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            mem_ack <= 1'b0;
            mcnt    <= 0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
            mcnt    <= 0;
        end else if (mem_req && !mem_abort) begin
            if (mcnt == LAT - 1) begin
                mem_ack <= 1'b1;
                if (mem_we) mm[{12'd0, mem_addr[19:1]}] = mem_wdata;
                else        mem_rdata <= mem_word({12'd0, mem_addr[19:1]});
            end else begin
                mcnt <= mcnt + 1;
            end
        end else begin
            mcnt <= 0;
        end
    end

    // ---------------- reference cache + scoreboard ----------------
    logic        mv [512];
    logic [9:0]  mt [512];
    logic [15:0] md [512];

    typedef struct {
        logic        we;
        logic        hit;
        logic [15:0] data;
        string       rq;
    } exp_t;
    exp_t q[$];

    function automatic exp_t predict(input logic we, input logic [19:0] a,
                                     input logic [15:0] wd, input logic cc, input string rq);
        exp_t e;
        int   ix;
        ix   = int'(a[9:1]);
        e.we = we;
        e.rq = rq;
        if (we) begin
            e.hit  = 1'b0;
            e.data = wd;
            if (cc) begin mv[ix] = 1'b1; mt[ix] = a[19:10]; md[ix] = wd; end
        end else begin
            e.hit  = cc && mv[ix] && (mt[ix] == a[19:10]);
            e.data = e.hit ? md[ix] : mem_word({12'd0, a[19:1]});
            if (!e.hit && cc) begin mv[ix] = 1'b1; mt[ix] = a[19:10]; md[ix] = e.data; end
        end
        return e;
    endfunction

    // monitor: pops one expected item per completion
    logic prev_ready = 1'b0;
    always @(negedge clk) begin
        cyc++;
        if (rst) begin
            prev_ready = 1'b0;
        end else begin
            if (cpu_ready) begin
                exp_t e;
                chk(!prev_ready, "R10", "ready held two cycles", 1, 0);
                if (q.size() == 0) begin
                    chk(1'b0, "R3", "unexpected completion", 1, 0);
                end else begin
                    e = q.pop_front();
                    if (!e.we) chk(cpu_rdata == e.data, e.rq, "read data", cpu_rdata, e.data);
                    chk(mem_abort == e.hit, e.rq, "abort/hit", mem_abort, e.hit);
                end
            end
            prev_ready = cpu_ready;
        end
    end

    // driver
    task automatic op(input logic we, input logic [19:0] a, input logic [15:0] wd,
                      input logic cc, input string rq, output logic hit, output int lat);
        exp_t e;
        e = predict(we, a, wd, cc, rq);
        hit = e.hit;
        q.push_back(e);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd; cpu_cacheable = cc;
        #0.5;
        chk(mem_req == 1'b1, "R8", "memory launch in accept cycle", mem_req, 1);
        if (we) chk(mem_we && mem_addr == a && mem_wdata == wd, "R5",
                    "write forwarded", {mem_we, mem_wdata}, {1'b1, wd});
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!cpu_ready && lat < 100);
        cpu_req = 1'b0;
    endtask

    task automatic rd(input logic [19:0] a, input logic cc, input string rq,
                      input logic exp_hit);
        logic h; int l;
        op(1'b0, a, 16'h0, cc, rq, h, l);
        chk(h == exp_hit, rq, "reference hit prediction", h, exp_hit);
        if (exp_hit) chk(l == 1, "R3", "hit latency", l, 1);
    endtask

    task automatic wr(input logic [19:0] a, input logic [15:0] d, input logic cc,
                      input string rq);
        logic h; int l;
        op(1'b1, a, d, cc, rq, h, l);
    endtask

    // reset, then hold a read through the clearing sweep (R1)
    task automatic reset_sweep(input logic [19:0] a);
        int k, bad;
        exp_t e;
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(!cpu_ready && !mem_req && !mem_abort, "R1", "outputs in reset",
            {cpu_ready, mem_req, mem_abort}, 0);
        for (int i = 0; i < 512; i++) mv[i] = 1'b0;
        e = predict(1'b0, a, 16'h0, 1'b1, "R1");
        q.push_back(e);
        rst = 1'b0;
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = a; cpu_cacheable = 1'b1;
        k = 0; bad = 0;
        do begin
            @(negedge clk);
            k++;
            if (cpu_ready) bad++;
        end while (!mem_req && k < 600);
        chk(k == 512, "R1", "cycle of first memory launch", k, 512);
        chk(bad == 0, "R1", "ready during sweep", bad, 0);
        while (!cpu_ready) @(negedge clk);
        cpu_req = 1'b0;
    endtask

    localparam logic [19:0] A  = 20'h12346;
    localparam logic [19:0] B  = 20'h0ABC8;
    localparam logic [19:0] C  = A ^ 20'h00400;   // same index, tag bit flipped
    localparam logic [19:0] C2 = A ^ 20'h80000;   // same index, top tag bit
    localparam logic [19:0] D  = A ^ 20'h00002;   // index bit flipped
    localparam logic [19:0] E  = 20'h5F01E;

    initial begin
        reset_sweep(A);                           // R1 + R4 miss
        rd(A, 1'b1, "R4", 1'b1);                  // fill then hit (R3)
        rd(A | 20'h1, 1'b1, "R9", 1'b1);          // bit 0 ignored
        wr(B, 16'hBEEF, 1'b1, "R5");
        rd(B, 1'b1, "R6", 1'b1);                  // write-allocate
        rd(D, 1'b1, "R2", 1'b0);                  // other index: miss
        rd(A, 1'b1, "R2", 1'b1);                  // A survives
        rd(C, 1'b1, "R2", 1'b0);                  // alias evicts
        rd(A, 1'b1, "R2", 1'b0);
        rd(C2, 1'b1, "R2", 1'b0);
        rd(A, 1'b1, "R2", 1'b0);
        rd(A, 1'b1, "R3", 1'b1);
        rd(A, 1'b0, "R7", 1'b0);                  // nc read never hits
        wr(A, 16'h1234, 1'b0, "R7");              // nc write: memory only
        rd(A, 1'b1, "R7", 1'b1);                  // stale cached copy
        rd(A, 1'b0, "R5", 1'b0);                  // memory has new word
        rd(E, 1'b0, "R7", 1'b0);                  // nc miss no fill
        rd(E, 1'b1, "R7", 1'b0);
        rd(E, 1'b1, "R4", 1'b1);
        wr(E, 16'h0F0F, 1'b1, "R6");              // update hit line
        rd(E, 1'b1, "R6", 1'b1);
        begin : mixed
            logic [31:0] s;
            s = 32'h1ACE5EED;
            for (int i = 0; i < 60; i++) begin
                logic h; int l;
                logic [19:0] a;
                s = s * 32'd1664525 + 32'd1013904223;
                a = {4'h3, s[27:20] & 8'h3, s[13:8] & 6'h0F, s[1:0]};
                op(s[29] & s[30], a, s[15:0], s[31] | s[28], "R4", h, l);
                if (h) chk(l == 1, "R3", "hit latency", l, 1);
            end
        end
        reset_sweep(E);                           // R1: E must miss now
        rd(E, 1'b1, "R1", 1'b1);
        repeat (3) @(negedge clk);
        chk(q.size() == 0, "R10", "outstanding completions", q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        tests++;
        fails++;
        $display("FAIL watchdog: run did not finish actual %0d expected %0d", cyc, 150000);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule